// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller Core

This core takes eight active-high interrupt request lines and picks the most urgent one with a fixed-priority resolver. Level 0 is the most urgent and level 7 the least urgent. While an eligible request exists, the core raises a single interrupt line to the processor. The processor answers with a train of acknowledge pulses. During those pulses the core places response bytes on an 8-bit data bus and qualifies them with a drive-enable output, which stands in for a tri-state buffer.

The mode input selects one of two response styles:
- **Call style:** three pulses. The bus carries a subroutine-call opcode, then the low byte and then the high byte of a handler address.
- **Pointer style:** two pulses. The bus is not driven on the first pulse, and the second pulse carries an 8-bit vector.

An in-service register records which levels are being handled and holds back equal and less urgent requests. Its bits are released either automatically at the end of the final pulse, or by a non-specific end-of-interrupt strobe.

Top module: `vpic_core`

## Requirements
- R1: `int_o` is high exactly when some request line sampled on the previous clock edge (and not just serviced) has a level number lower than every level currently in service; level 0 is most urgent.
- R2: In call style (`mode_call_i`=1), the byte driven during the first acknowledge pulse is 8'hCD with `data_oe_o` high.
- R3: In call style, the second pulse drives bits 7:0 and the third pulse drives bits 15:8 of `addr_base_i + 4*level`.
- R4: In call style, the rising edge of the first pulse marks the chosen level in service, so requests at that level or less urgent ones no longer raise `int_o`.
- R5: In pointer style, `data_oe_o` stays low during the first pulse. The second pulse marks the chosen level in service and drives `{vec_base_i, level[2:0]}`.
- R6: With `auto_eoi_i`=1, the serviced level leaves service on the cycle after the final pulse ends (third pulse in call style, second in pointer style).
- R7: With `auto_eoi_i`=0, an in-service level stays in service until a one-cycle `eoi_i` strobe. That strobe releases only the most urgent in-service level.
- R8: If no eligible request exists at the service point, the core services level 7, in both vector and address form.
- R9: `data_oe_o` is low whenever `ack_i` is low, and is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_i | input | 8 | Request lines, active high, bit n is level n |
| ack_i | input | 1 | Acknowledge pulse from the processor, high while active |
| mode_call_i | input | 1 | 1 selects three-pulse call style, 0 selects two-pulse pointer style; held stable during a sequence |
| auto_eoi_i | input | 1 | 1 releases the serviced level automatically after the last pulse |
| eoi_i | input | 1 | Non-specific end-of-interrupt strobe, one cycle |
| vec_base_i | input | 5 | Upper five bits of the pointer-style vector |
| addr_base_i | input | 16 | Handler table base for call style |
| int_o | output | 1 | Interrupt request to the processor |
| data_o | output | 8 | Response byte |
| data_oe_o | output | 1 | Drive enable for `data_o` |

## Verification
The bench targets four situations.

- **Vanished request.** A request is dropped between `int_o` rising and the service pulse. A design that kept servicing the stale level, rather than substituting level 7, returns the wrong vector or address byte.
- **Nested service.** A more urgent level is serviced on top of a less urgent one, and the end-of-interrupt strobe is then issued. A design that released the wrong bit leaves the middle level blocked and `int_o` low.
- **Pointer-style first pulse.** A design that drives the bus on this pulse is caught by the enable check.
- **Release timing.** The bench compares automatic and explicit release. A design that cleared the in-service bit early, late or never shows a wrong `int_o` once the request line is held high after the sequence.

// File: rtl/vpic_pkg.sv
// Package vpic_pkg
// Shared constants and helpers for the vectored interrupt controller.
// Assumes an 8-bit response bus and a handler address two bytes wide.
package vpic_pkg;

    localparam int DATA_W      = 8;
    localparam int ADDR_W      = 2 * DATA_W;
    localparam int SLOT_SH     = 2;
    localparam logic [DATA_W-1:0] CALL_OPCODE = 8'hCD;

    typedef logic [1:0] ack_step_t;

    localparam ack_step_t STEP_FIRST  = 2'd0;
    localparam ack_step_t STEP_SECOND = 2'd1;
    localparam ack_step_t STEP_THIRD  = 2'd2;

    // Pulse index at which the in-service bit is set.
    function automatic ack_step_t svc_step(input logic call_mode);
        return call_mode ? STEP_FIRST : STEP_SECOND;
    endfunction

    // Pulse index of the last pulse in a sequence.
    function automatic ack_step_t last_step(input logic call_mode);
        return call_mode ? STEP_THIRD : STEP_SECOND;
    endfunction

endpackage

// File: rtl/vpic_prio_enc.sv
// Module vpic_prio_enc
// Finds the lowest-numbered set bit of a vector (most urgent level).
// Purely combinational; idx is zero when no bit is set.
module vpic_prio_enc #(
    parameter int W  = 8,
    parameter int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx
);

    // Scan from the top so the lowest set index is the one kept.
    always_comb begin
        any = |vec;
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end

endmodule

// File: rtl/vpic_resolver.sv
// Module vpic_resolver
// Fixed-priority resolver: a request is eligible only when its level is
// more urgent than every in-service level. Also reports the most urgent
// in-service level for non-specific end of interrupt.
module vpic_resolver #(
    parameter int N_LVL = 8,
    parameter int LVL_W = $clog2(N_LVL)
) (
    input  logic [N_LVL-1:0] irr,
    input  logic [N_LVL-1:0] isr,
    output logic             pend_valid,
    output logic [LVL_W-1:0] pend_lvl,
    output logic             isr_any,
    output logic [LVL_W-1:0] isr_top
);

    logic [N_LVL-1:0] eligible;

    vpic_prio_enc #(.W(N_LVL), .IW(LVL_W)) u_isr_enc (
        .vec (isr),
        .any (isr_any),
        .idx (isr_top)
    );

    // Mask each request by the in-service ceiling.
    for (genvar g = 0; g < N_LVL; g++) begin : g_elig
        assign eligible[g] = irr[g] & (~isr_any | (LVL_W'(g) < isr_top));
    end

    vpic_prio_enc #(.W(N_LVL), .IW(LVL_W)) u_req_enc (
        .vec (eligible),
        .any (pend_valid),
        .idx (pend_lvl)
    );

endmodule

// File: rtl/vpic_ack_seq.sv
// Module vpic_ack_seq
// Counts acknowledge pulses of a sequence. Flags the service point (rising
// edge of the service pulse) and the end of the final pulse. Assumes the
// mode input is steady from the first pulse to the last.
module vpic_ack_seq
    import vpic_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ack_i,
    input  logic      mode_call_i,
    output ack_step_t step,
    output logic      ack_q,
    output logic      svc_fire,
    output logic      fin_fall
);

    ack_step_t step_q;
    logic      ack_d;
    logic      ack_fall;

    assign ack_fall = ack_d & ~ack_i;

    // Track the pulse level and advance the step at each pulse end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_d  <= 1'b0;
            step_q <= STEP_FIRST;
        end else begin
            ack_d <= ack_i;
            if (ack_fall) begin
                if (step_q == last_step(mode_call_i)) step_q <= STEP_FIRST;
                else                                  step_q <= step_q + 2'd1;
            end
        end
    end

    // Decode the event strobes from the step counter and edges.
    always_comb begin
        svc_fire = ack_i & ~ack_d & (step_q == svc_step(mode_call_i));
        fin_fall = ack_fall & (step_q == last_step(mode_call_i));
    end

    assign step  = step_q;
    assign ack_q = ack_d;

endmodule

// File: rtl/vpic_resp_mux.sv
// Module vpic_resp_mux
// Chooses the byte for the current acknowledge pulse and its drive enable.
// Assumes the handler address is exactly two bus bytes wide.
module vpic_resp_mux
    import vpic_pkg::*;
#(
    parameter int LVL_W = 3,
    parameter int VB_W  = DATA_W - LVL_W
) (
    input  logic              ack_i,
    input  logic              mode_call_i,
    input  ack_step_t         step,
    input  logic [LVL_W-1:0]  lvl,
    input  logic [VB_W-1:0]   vec_base_i,
    input  logic [ADDR_W-1:0] addr_base_i,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe_o
);

    localparam int PAD_W = ADDR_W - LVL_W - SLOT_SH;

    logic [ADDR_W-1:0] handler;

    assign handler = addr_base_i + {{PAD_W{1'b0}}, lvl, {SLOT_SH{1'b0}}};

    // Select the byte and enable for the active pulse.
    always_comb begin
        data_oe_o = 1'b0;
        data_o    = '0;
        if (ack_i) begin
            if (mode_call_i) begin
                data_oe_o = 1'b1;
                case (step)
                    STEP_FIRST:  data_o = CALL_OPCODE;
                    STEP_SECOND: data_o = handler[DATA_W-1:0];
                    default:     data_o = handler[ADDR_W-1:DATA_W];
                endcase
            end else if (step == STEP_SECOND) begin
                data_oe_o = 1'b1;
                data_o    = {vec_base_i, lvl};
            end
        end
    end

endmodule

// File: rtl/vpic_core.sv
// Module vpic_core
// Top of the vectored priority interrupt controller. Holds the request
// and in-service registers and the level under service, and ties
// together the resolver, acknowledge sequencer and response multiplexer.
// Assumes request lines are synchronous to clk and eoi_i is one cycle long.
module vpic_core
    import vpic_pkg::*;
#(
    parameter int N_LVL = 8,
    parameter int LVL_W = $clog2(N_LVL),
    parameter int VB_W  = DATA_W - LVL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_LVL-1:0]  irq_i,
    input  logic              ack_i,
    input  logic              mode_call_i,
    input  logic              auto_eoi_i,
    input  logic              eoi_i,
    input  logic [VB_W-1:0]   vec_base_i,
    input  logic [ADDR_W-1:0] addr_base_i,
    output logic              int_o,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe_o
);

    localparam logic [LVL_W-1:0] FALLBACK_LVL = LVL_W'(N_LVL - 1);

    logic [N_LVL-1:0] irr_q;
    logic [N_LVL-1:0] isr_q;
    logic [LVL_W-1:0] cur_lvl_q;
    logic             pend_valid;
    logic [LVL_W-1:0] pend_lvl;
    logic             isr_any;
    logic [LVL_W-1:0] isr_top;
    ack_step_t        step;
    logic             ack_q;
    logic             svc_fire;
    logic             fin_fall;
    logic [LVL_W-1:0] lvl_fire;
    logic [LVL_W-1:0] lvl_sel;
    logic [N_LVL-1:0] set_mask;
    logic [N_LVL-1:0] clr_mask;

    vpic_resolver #(.N_LVL(N_LVL), .LVL_W(LVL_W)) u_res (
        .irr        (irr_q),
        .isr        (isr_q),
        .pend_valid (pend_valid),
        .pend_lvl   (pend_lvl),
        .isr_any    (isr_any),
        .isr_top    (isr_top)
    );

    vpic_ack_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .ack_i       (ack_i),
        .mode_call_i (mode_call_i),
        .step        (step),
        .ack_q       (ack_q),
        .svc_fire    (svc_fire),
        .fin_fall    (fin_fall)
    );

    // Pick the serviced level and build the set and clear masks.
    always_comb begin
        lvl_fire = pend_valid ? pend_lvl : FALLBACK_LVL;
        lvl_sel  = svc_fire ? lvl_fire : cur_lvl_q;
        set_mask = svc_fire ? (N_LVL'(1) << lvl_fire) : '0;
        clr_mask = '0;
        if (eoi_i && isr_any)       clr_mask = clr_mask | (N_LVL'(1) << isr_top);
        if (fin_fall && auto_eoi_i) clr_mask = clr_mask | (N_LVL'(1) << cur_lvl_q);
    end

    // Update the request, in-service and current-level registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr_q     <= '0;
            isr_q     <= '0;
            cur_lvl_q <= '0;
        end else begin
            irr_q <= irq_i & ~set_mask;
            isr_q <= (isr_q & ~clr_mask) | set_mask;
            if (svc_fire) cur_lvl_q <= lvl_fire;
        end
    end

    assign int_o = pend_valid;

    vpic_resp_mux #(.LVL_W(LVL_W), .VB_W(VB_W)) u_mux (
        .ack_i       (ack_i),
        .mode_call_i (mode_call_i),
        .step        (step),
        .lvl         (lvl_sel),
        .vec_base_i  (vec_base_i),
        .addr_base_i (addr_base_i),
        .data_o      (data_o),
        .data_oe_o   (data_oe_o)
    );

endmodule

// File: rtl/vpic_core_chk.sv
// Module vpic_core_chk
// Assertion checker for vpic_core, attached with the bind below.
// Observes ports plus the sequencer step, in-service register and level.
module vpic_core_chk
    import vpic_pkg::*;
#(
    parameter int N_LVL = 8,
    parameter int LVL_W = $clog2(N_LVL)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack_i,
    input logic              mode_call_i,
    input logic              auto_eoi_i,
    input logic              eoi_i,
    input logic              data_oe_o,
    input logic [DATA_W-1:0] data_o,
    input ack_step_t         step,
    input logic              ack_q,
    input logic [N_LVL-1:0]  isr,
    input logic [LVL_W-1:0]  cur_lvl,
    input logic              svc_fire,
    input logic              pend_valid
);

    a_r9_no_drive_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_i |-> !data_oe_o);

    a_r2_call_opcode: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe_o && mode_call_i && step == STEP_FIRST) |-> data_o == CALL_OPCODE);

    a_r5_ptr_first_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_call_i && step == STEP_FIRST) |-> !data_oe_o);

    a_r6_auto_release: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_q && !ack_i && step == last_step(mode_call_i) && auto_eoi_i)
        |=> !isr[$past(cur_lvl)]);

    a_r7_held_without_eoi: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_eoi_i && !eoi_i) |=> ((isr & $past(isr)) == $past(isr)));

    a_r8_fallback_level: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_fire && !pend_valid) |=> isr[N_LVL-1]);

endmodule

bind vpic_core vpic_core_chk #(.N_LVL(N_LVL), .LVL_W(LVL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack_i       (ack_i),
    .mode_call_i (mode_call_i),
    .auto_eoi_i  (auto_eoi_i),
    .eoi_i       (eoi_i),
    .data_oe_o   (data_oe_o),
    .data_o      (data_o),
    .step        (step),
    .ack_q       (ack_q),
    .isr         (isr_q),
    .cur_lvl     (cur_lvl_q),
    .svc_fire    (svc_fire),
    .pend_valid  (pend_valid)
);

// File: tb/vpic_core_tb_top.sv
// Bench for vpic_core: a behavioural reference model updated on each rising
// edge, compared with the outputs on each falling edge, plus directed checks.
module vpic_core_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  irq = '0;
    logic        ack = 1'b0;
    logic        call = 1'b1;
    logic        auto = 1'b0;
    logic        eoi = 1'b0;
    logic [4:0]  vb = 5'h15;
    logic [15:0] ab = 16'h12F0;
    logic        int_o;
    logic [7:0]  data_o;
    logic        data_oe_o;

    int    n_chk = 0;
    int    n_err = 0;
    bit    done = 0;
    string cur_req = "R9";
    bit    p_oe;
    int    p_data;

    always #4 clk = ~clk;

    vpic_core dut_i (
        .clk(clk), .rst_n(rst_n), .irq_i(irq), .ack_i(ack),
        .mode_call_i(call), .auto_eoi_i(auto), .eoi_i(eoi),
        .vec_base_i(vb), .addr_base_i(ab),
        .int_o(int_o), .data_o(data_o), .data_oe_o(data_oe_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    bit [7:0] m_irr, m_isr;
    bit       m_ackq;
    int       m_step, m_lvl;

    function automatic int first1(input bit [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return 8;
    endfunction

    function automatic int m_resolve();
        int ceil_l;
        ceil_l = first1(m_isr);
        for (int i = 0; i < ceil_l; i++) if (m_irr[i]) return i;
        return -1;
    endfunction

    always @(posedge clk) begin : model
        int svc, last, r, lvl, t;
        bit fire;
        bit [7:0] clr, set;
        if (!rst_n) begin
            m_irr = '0; m_isr = '0; m_ackq = 0; m_step = 0; m_lvl = 0;
        end else begin
            svc  = call ? 0 : 1;
            last = call ? 2 : 1;
            r    = m_resolve();
            fire = ack && !m_ackq && (m_step == svc);
            clr = '0; set = '0; lvl = 0;
            t = first1(m_isr);
            if (eoi && t < 8) clr[t] = 1'b1;
            if (m_ackq && !ack && m_step == last && auto) clr[m_lvl] = 1'b1;
            if (fire) begin
                lvl = (r >= 0) ? r : 7;
                set[lvl] = 1'b1;
            end
            m_irr = irq & ~set;
            m_isr = (m_isr & ~clr) | set;
            if (m_ackq && !ack) m_step = (m_step == last) ? 0 : m_step + 1;
            if (fire) m_lvl = lvl;
            m_ackq = ack;
        end
    end

    always @(negedge clk) begin : compare
        int r, lsel, exp_d, addr;
        bit exp_oe, fire;
        if (rst_n && !done) begin
            r    = m_resolve();
            fire = ack && !m_ackq && (m_step == (call ? 0 : 1));
            lsel = fire ? ((r >= 0) ? r : 7) : m_lvl;
            exp_oe = ack && (call || m_step == 1);
            addr = (ab + lsel * 4) & 16'hFFFF;
            if (call) exp_d = (m_step == 0) ? 8'hCD : (m_step == 1) ? (addr & 8'hFF) : (addr >> 8);
            else      exp_d = vb * 8 + lsel;
            chk(int_o == (r >= 0), "R1", "int_o", int_o, (r >= 0));
            chk(data_oe_o == exp_oe, ack ? cur_req : "R9", "data_oe_o", data_oe_o, exp_oe);
            if (exp_oe) chk(data_o == exp_d[7:0], cur_req, "data_o", data_o, exp_d);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse();
        @(posedge clk); #1 ack = 1'b1;
        @(negedge clk);
        p_oe = data_oe_o; p_data = data_o;
        @(posedge clk); #1 ack = 1'b0;
        cyc(2);
    endtask

    task automatic strobe_eoi();
        @(posedge clk); #1 eoi = 1'b1;
        @(posedge clk); #1 eoi = 1'b0;
    endtask

    task automatic see_int(input string req, input bit exp);
        @(negedge clk);
        chk(int_o == exp, req, "int_o", int_o, exp);
    endtask

    // ---------------- directed scenarios ----------------
    initial begin
        cyc(3);
        @(negedge clk);
        chk(int_o == 1'b0, "R1", "reset int_o", int_o, 0);
        chk(data_oe_o == 1'b0, "R9", "reset data_oe_o", data_oe_o, 0);
        @(posedge clk); #1 rst_n = 1'b1;

        // Call style, explicit release, level 3 with level 5 also pending
        call = 1; auto = 0; ab = 16'h12F0;
        irq = 8'h28; cyc(2);
        see_int("R1", 1);
        cur_req = "R2"; pulse();
        chk(p_oe && p_data == 8'hCD, "R2", "call opcode", p_data, 8'hCD);
        cur_req = "R3"; pulse();
        chk(p_data == 8'hFC, "R3", "address low", p_data, 8'hFC);
        pulse();
        chk(p_data == 8'h12, "R3", "address high", p_data, 8'h12);
        see_int("R4", 0);
        cur_req = "R7"; cyc(4);
        see_int("R7", 0);
        strobe_eoi();
        see_int("R7", 1);
        irq = 8'h00; cyc(3);

        // Pointer style, automatic release, level 6
        call = 0; auto = 1; vb = 5'h15;
        irq = 8'h40; cyc(2);
        cur_req = "R5"; pulse();
        chk(p_oe == 1'b0, "R5", "first pulse drive", p_oe, 0);
        pulse();
        chk(p_oe && p_data == 8'hAE, "R5", "pointer vector", p_data, 8'hAE);
        see_int("R6", 1);
        irq = 8'h00; cyc(3);

        // Pointer style, explicit release keeps level 6 blocked
        auto = 0; irq = 8'h40; cyc(2);
        cur_req = "R7"; pulse(); pulse();
        see_int("R7", 0);
        strobe_eoi();
        see_int("R7", 1);
        irq = 8'h00; cyc(3);

        // Vanished request, pointer style
        auto = 1; irq = 8'h04; cyc(2);
        see_int("R1", 1);
        irq = 8'h00; cyc(2);
        see_int("R1", 0);
        cur_req = "R8"; pulse(); pulse();
        chk(p_data == 8'hAF, "R8", "fallback vector", p_data, 8'hAF);
        cyc(2);

        // Vanished request, call style: address of level 7
        call = 1; auto = 0; irq = 8'h01; cyc(2);
        irq = 8'h00; cyc(2);
        pulse();
        chk(p_data == 8'hCD, "R8", "opcode on fallback", p_data, 8'hCD);
        pulse();
        chk(p_data == 8'h0C, "R8", "fallback address low", p_data, 8'h0C);
        pulse();
        chk(p_data == 8'h13, "R8", "fallback address high", p_data, 8'h13);
        cur_req = "R7"; strobe_eoi(); cyc(2);

        // Nested service, explicit release of the most urgent level only
        call = 0; auto = 0; irq = 8'h20; cyc(2);
        cur_req = "R5"; pulse(); pulse();
        irq = 8'h24; cyc(2);
        see_int("R1", 1);
        pulse(); pulse();
        chk(p_data == 8'hAA, "R5", "nested vector", p_data, 8'hAA);
        irq = 8'h08; cyc(2);
        see_int("R1", 0);
        cur_req = "R7"; strobe_eoi();
        see_int("R7", 1);
        strobe_eoi();
        see_int("R7", 1);
        irq = 8'h00; cyc(3);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule